// File: doc/BRIEF.md
# Double-Buffered Four-Channel PWM Compare

This block turns a shared 8-bit timer count into four pulse-width-modulated outputs. Software programs a duty value for each channel through a small write port. Each channel also has a compare register that software cannot reach. The compare register takes a copy of the duty value only when the counter wraps. Because of this, a duty change made partway through a period never cuts the waveform short and never stretches it.

The counter, its prescaler and its reload logic live outside this block. They supply the live count, a one-cycle wrap pulse and the reload value the counter restarts from. All four outputs are registered. Every output is set high by the wrap pulse and cleared when the count reaches that channel's compare value. The write port follows a valid/ready handshake. Ready is low while reset is applied and stays high after that, so the port never applies back-pressure once the block is running.

Top module: `dbuf_pwm_bank`

## Requirements
- R1: `wr_ready_o` is 0 while `rst_n` is low and 1 from the first clock edge after reset is released. A write takes effect only in a cycle where `wr_valid_i` and `wr_ready_o` are both 1.
- R2: `rd_data_o` returns the last value written to the duty register chosen by `rd_sel_i` (channel index 0 to 3). It does not return the active compare value.
- R3: A channel's compare register changes only in a cycle where `ovf_i` is 1, and then it takes that channel's duty value. A duty write made in the middle of a period leaves the running waveform unchanged until the next wrap.
- R4: When a write to channel k is accepted in the same cycle as `ovf_i`, compare register k loads the newly written value.
- R5: After each clock edge that samples `ovf_i` = 1, all four bits of `pwm_o` are 1.
- R6: If `ovf_i` = 0, `cnt_i` equals the channel's compare value, and that compare value differs from `reload_i`, the channel's output is 0 after the clock edge. Otherwise, with no wrap, the output holds its value.
- R7: If a channel's compare value equals `reload_i`, its output stays high for the whole period.
- R8: Reset clears every duty register and compare register to 0 and drives `pwm_o` to 0.
- R9: The channels run independently from the same counter. A compare value the counter never reaches leaves that channel high for the whole period.
- R10: When a compare match and `ovf_i` fall in the same cycle, the output is 1 after the edge.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| cnt_i | input | 8 | Live counter value |
| ovf_i | input | 1 | One-cycle wrap (reload) pulse of the counter |
| reload_i | input | 8 | Value the counter reloads to on wrap |
| wr_valid_i | input | 1 | Duty write request |
| wr_ready_o | output | 1 | Write port can accept |
| wr_sel_i | input | 2 | Channel index of the write |
| wr_data_i | input | 8 | Duty value to write |
| rd_sel_i | input | 2 | Channel index of the readback |
| rd_data_o | output | 8 | Duty register readback |
| pwm_o | output | 4 | PWM outputs, bit k is channel k |

## Verification
The four channels are given duty values that are reached mid-period, equal to the reload value, and below the reload value. This separates the normal set/clear waveform from the full-high case and from a compare value that is never reached. Duty writes are placed mid-period and exactly in the wrap cycle, which shows whether the shadow copy happens only at the wrap and whether a write in the wrap cycle is picked up. Runs with the counter stepping every cycle, every second cycle and every fourth cycle decide whether a match that falls in the wrap cycle loses to the set. Readback with a changing channel index while writes are pending shows whether the port returns the duty register rather than the shadow.

// File: rtl/pwmb_pkg.sv
package pwmb_pkg;
  parameter int CNT_W = 8;
  parameter int N_CH  = 4;
  localparam int SEL_W = (N_CH > 1) ? $clog2(N_CH) : 1;
  typedef logic [CNT_W-1:0] cnt_t;
  typedef logic [SEL_W-1:0] sel_t;
endpackage

// File: rtl/pwmb_wr_port.sv
module pwmb_wr_port
  import pwmb_pkg::*;
#(
  parameter int NCH = N_CH,
  localparam int SW = (NCH > 1) ? $clog2(NCH) : 1
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          valid_i,
  input  logic [SW-1:0] sel_i,
  output logic          ready_o,
  output logic [NCH-1:0] hit_o
);
  logic rdy_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) rdy_q <= 1'b0;
    else        rdy_q <= 1'b1;
  end

  assign ready_o = rdy_q;

  for (genvar k = 0; k < NCH; k++) begin : g_hit
    assign hit_o[k] = valid_i && rdy_q && (sel_i == SW'(k));
  end
endmodule

// File: rtl/pwmb_duty_bank.sv
module pwmb_duty_bank
  import pwmb_pkg::*;
#(
  parameter int NCH = N_CH,
  parameter int W   = CNT_W,
  localparam int SW = (NCH > 1) ? $clog2(NCH) : 1
) (
  input  logic                  clk,
  input  logic                  rst_n,
  input  logic [NCH-1:0]        hit_i,
  input  logic [W-1:0]          wdata_i,
  input  logic [SW-1:0]         rsel_i,
  output logic [W-1:0]          rdata_o,
  output logic [NCH-1:0][W-1:0] duty_o
);
  logic [NCH-1:0][W-1:0] duty_q;

  for (genvar k = 0; k < NCH; k++) begin : g_reg
    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)        duty_q[k] <= '0;
      else if (hit_i[k]) duty_q[k] <= wdata_i;
    end
  end

  always_comb begin
    rdata_o = '0;
    for (int k = 0; k < NCH; k++) begin
      if (rsel_i == SW'(k)) rdata_o = duty_q[k];
    end
  end

  assign duty_o = duty_q;
endmodule

// File: rtl/pwmb_chan.sv
module pwmb_chan
  import pwmb_pkg::*;
#(
  parameter int W = CNT_W
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic [W-1:0] cnt_i,
  input  logic         ovf_i,
  input  logic [W-1:0] reload_i,
  input  logic [W-1:0] duty_i,
  input  logic         hit_i,
  input  logic [W-1:0] wdata_i,
  output logic [W-1:0] cmp_o,
  output logic         pwm_o
);
  logic [W-1:0] cmp_q;
  logic         out_q;
  logic         match;
  logic [W-1:0] next_cmp;

  // A write in the wrap cycle bypasses the duty register
  assign next_cmp = hit_i ? wdata_i : duty_i;
  // Compare equal to reload keeps the output high all period
  assign match    = (cnt_i == cmp_q) && (cmp_q != reload_i);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)     cmp_q <= '0;
    else if (ovf_i) cmp_q <= next_cmp;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)     out_q <= 1'b0;
    else if (ovf_i) out_q <= 1'b1;
    else if (match) out_q <= 1'b0;
  end

  assign cmp_o = cmp_q;
  assign pwm_o = out_q;
endmodule

// File: rtl/dbuf_pwm_bank.sv
module dbuf_pwm_bank
  import pwmb_pkg::*;
#(
  parameter int NCH = N_CH,
  parameter int W   = CNT_W,
  localparam int SW = (NCH > 1) ? $clog2(NCH) : 1
) (
  input  logic           clk,
  input  logic           rst_n,
  input  logic [W-1:0]   cnt_i,
  input  logic           ovf_i,
  input  logic [W-1:0]   reload_i,
  input  logic           wr_valid_i,
  output logic           wr_ready_o,
  input  logic [SW-1:0]  wr_sel_i,
  input  logic [W-1:0]   wr_data_i,
  input  logic [SW-1:0]  rd_sel_i,
  output logic [W-1:0]   rd_data_o,
  output logic [NCH-1:0] pwm_o
);
  logic [NCH-1:0]        hit;
  logic [NCH-1:0][W-1:0] duty_all;
  logic [NCH-1:0][W-1:0] cmp_all;

  pwmb_wr_port #(.NCH(NCH)) u_wr (
    .clk     (clk),
    .rst_n   (rst_n),
    .valid_i (wr_valid_i),
    .sel_i   (wr_sel_i),
    .ready_o (wr_ready_o),
    .hit_o   (hit)
  );

  pwmb_duty_bank #(.NCH(NCH), .W(W)) u_duty (
    .clk     (clk),
    .rst_n   (rst_n),
    .hit_i   (hit),
    .wdata_i (wr_data_i),
    .rsel_i  (rd_sel_i),
    .rdata_o (rd_data_o),
    .duty_o  (duty_all)
  );

  for (genvar k = 0; k < NCH; k++) begin : g_ch
    pwmb_chan #(.W(W)) u_ch (
      .clk      (clk),
      .rst_n    (rst_n),
      .cnt_i    (cnt_i),
      .ovf_i    (ovf_i),
      .reload_i (reload_i),
      .duty_i   (duty_all[k]),
      .hit_i    (hit[k]),
      .wdata_i  (wr_data_i),
      .cmp_o    (cmp_all[k]),
      .pwm_o    (pwm_o[k])
    );
  end
endmodule

// File: rtl/pwmb_chk.sv
module pwmb_chk #(
  parameter int NCH = 4,
  parameter int W   = 8,
  localparam int SW = (NCH > 1) ? $clog2(NCH) : 1
) (
  input logic                  clk,
  input logic                  rst_n,
  input logic                  ovf_i,
  input logic                  wr_valid_i,
  input logic                  wr_ready_o,
  input logic [SW-1:0]         wr_sel_i,
  input logic [W-1:0]          wr_data_i,
  input logic [NCH-1:0]        pwm_o,
  input logic [NCH-1:0][W-1:0] cmp_all
);
  // R1
  ready_up_chk: assert property (@(posedge clk) disable iff (!rst_n)
    1'b1 |=> wr_ready_o);

  // R3
  shadow_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !ovf_i |=> $stable(cmp_all));

  // R4
  same_cycle_load_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (ovf_i && wr_valid_i && wr_ready_o) |=> (cmp_all[$past(wr_sel_i)] == $past(wr_data_i)));

  // R5
  set_on_wrap_chk: assert property (@(posedge clk) disable iff (!rst_n)
    ovf_i |=> (&pwm_o));

  // R6
  rise_only_wrap_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (|(pwm_o & ~$past(pwm_o))) |-> $past(ovf_i));
endmodule

bind dbuf_pwm_bank pwmb_chk #(.NCH(NCH), .W(W)) u_chk (
  .clk        (clk),
  .rst_n      (rst_n),
  .ovf_i      (ovf_i),
  .wr_valid_i (wr_valid_i),
  .wr_ready_o (wr_ready_o),
  .wr_sel_i   (wr_sel_i),
  .wr_data_i  (wr_data_i),
  .pwm_o      (pwm_o),
  .cmp_all    (cmp_all)
);

// File: tb/dbuf_pwm_bank_tb.sv
module dbuf_pwm_bank_tb;
  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic [7:0] cnt_i = '0;
  logic       ovf_i = 1'b0;
  logic [7:0] reload_i = 8'd200;
  logic       wr_valid_i = 1'b0;
  logic       wr_ready_o;
  logic [1:0] wr_sel_i = '0;
  logic [7:0] wr_data_i = '0;
  logic [1:0] rd_sel_i = '0;
  logic [7:0] rd_data_o;
  logic [3:0] pwm_o;

  int checks = 0;
  int errors = 0;
  bit done = 0;
  string tag = "R8";

  // counter generator state
  int cnt_v = 0;
  int pc = 0;
  int div = 1;
  logic [15:0] lf = 16'hACE1;

  // reference model
  int m_duty[4];
  int m_cmp[4];
  bit m_out[4];
  bit m_rdy = 0;

  always #5 clk = ~clk;

  dbuf_pwm_bank u_dut (
    .clk(clk), .rst_n(rst_n), .cnt_i(cnt_i), .ovf_i(ovf_i), .reload_i(reload_i),
    .wr_valid_i(wr_valid_i), .wr_ready_o(wr_ready_o), .wr_sel_i(wr_sel_i),
    .wr_data_i(wr_data_i), .rd_sel_i(rd_sel_i), .rd_data_o(rd_data_o), .pwm_o(pwm_o)
  );

  initial begin
    for (int k = 0; k < 4; k++) begin m_duty[k] = 0; m_cmp[k] = 0; m_out[k] = 0; end
  end

  always @(posedge clk) begin
    if (!rst_n) begin
      m_rdy = 0;
      for (int k = 0; k < 4; k++) begin m_duty[k] = 0; m_cmp[k] = 0; m_out[k] = 0; end
    end else begin
      bit acc;
      acc = wr_valid_i && m_rdy;
      for (int k = 0; k < 4; k++) begin
        if (ovf_i) m_out[k] = 1;
        else if (int'(cnt_i) == m_cmp[k] && m_cmp[k] != int'(reload_i)) m_out[k] = 0;
        if (ovf_i) m_cmp[k] = (acc && int'(wr_sel_i) == k) ? int'(wr_data_i) : m_duty[k];
      end
      if (acc) m_duty[wr_sel_i] = int'(wr_data_i);
      m_rdy = 1;
    end
  end

  task automatic check_now();
    logic [3:0] exp_pwm;
    for (int k = 0; k < 4; k++) exp_pwm[k] = m_out[k];
    checks++;
    if (pwm_o !== exp_pwm) begin
      errors++;
      $display("FAIL %s pwm_o actual=%b expected=%b t=%0t", tag, pwm_o, exp_pwm, $time);
    end
    checks++;
    if (rd_data_o !== 8'(m_duty[rd_sel_i])) begin
      errors++;
      $display("FAIL R2 rd_data_o actual=%0d expected=%0d", rd_data_o, m_duty[rd_sel_i]);
    end
    checks++;
    if (wr_ready_o !== m_rdy) begin
      errors++;
      $display("FAIL R1 wr_ready_o actual=%b expected=%b", wr_ready_o, m_rdy);
    end
  endtask

  // one cycle: check, then drive the next set of inputs
  task automatic step(input bit v, input int sel, input int data);
    bit tick;
    @(negedge clk);
    check_now();
    lf = {lf[14:0], lf[15] ^ lf[13] ^ lf[12] ^ lf[10]};
    rd_sel_i = lf[1:0];
    wr_valid_i = v;
    wr_sel_i = 2'(sel);
    wr_data_i = 8'(data);
    tick = (pc >= div - 1);
    cnt_i = 8'(cnt_v);
    ovf_i = tick && (cnt_v == 255);
    pc = tick ? 0 : pc + 1;
    if (tick) cnt_v = (cnt_v == 255) ? int'(reload_i) : cnt_v + 1;
  endtask

  task automatic run(input int n);
    for (int i = 0; i < n; i++) step(0, 0, 0);
  endtask

  task automatic wait_wrap();
    while (!((pc >= div - 1) && cnt_v == 255)) step(0, 0, 0);
  endtask

  initial begin
    // R8 reset state, R1 writes during reset ignored
    tag = "R8";
    step(1, 0, 77);
    step(1, 1, 88);
    step(0, 0, 0);
    @(negedge clk);
    rst_n = 1'b1;
    run(2);

    // R6 R7 R9 basic waveforms with four distinct duties
    tag = "R6";
    step(1, 0, 220);
    step(1, 1, 250);
    step(1, 2, 200);   // R7 equals reload
    step(1, 3, 100);   // R9 never reached
    run(200);
    tag = "R7";
    run(60);
    tag = "R9";
    run(60);

    // R3 mid-period write, waveform unchanged until wrap
    tag = "R3";
    wait_wrap();
    run(20);
    step(1, 0, 240);
    run(10);
    step(1, 0, 210);
    run(150);

    // R4 write lands in the wrap cycle
    tag = "R4";
    wait_wrap();
    step(1, 1, 230);
    run(120);
    wait_wrap();
    step(1, 3, 205);
    run(120);

    // R10 match in wrap cycle, div 1 then div 2
    tag = "R10";
    step(1, 0, 255);
    run(200);
    div = 2;
    run(300);

    // R5 random writes with a slower counter
    tag = "R5";
    div = 4;
    for (int i = 0; i < 1500; i++) begin
      lf = {lf[14:0], lf[15] ^ lf[13] ^ lf[12] ^ lf[10]};
      if (lf[3:0] == 4'h5) step(1, int'(lf[5:4]), 200 + int'(lf[11:6]));
      else step(0, 0, 0);
    end
    tag = "R2";
    run(50);

    done = 1;
    $display("  CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    #(200000 * 10);
    if (!done) begin
      errors++;
      $display("FAIL watchdog expired actual=running expected=done");
      $display("  CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end
endmodule